// File: doc/BRIEF.md
# Hysteretic Fan Duty Controller

This block turns a stream of raw temperature codes into a fan drive signal. Each new code arrives with a one-cycle valid strobe. The code is placed on a ladder of eight programmable thresholds, which splits the code range into nine intervals. Five of those intervals each name one duty setting: 0%, 25%, 50%, 75% or 100%. The four intervals between neighbouring settings are dead bands. In a dead band the setting already in force is kept. A fan that heats up through a band therefore keeps its lower speed, and a fan that cools down through the same band keeps its higher speed.

The chosen setting is turned into a free-running PWM waveform. Both the period and the high time are counted in clock cycles. A new high time is taken up only at the next period boundary. The block also reports the chosen setting, its high time in cycles, and a single-cycle strobe each time the setting moves upward. Thresholds are loaded from parameters at reset. Each one can be overwritten at run time through a small write port. Codes and thresholds are compared as raw unsigned numbers, with no unit conversion.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: While and after reset, before any sample: duty_level_o is 4 (100%), duty_width_o equals PERIOD, pwm_o is high and duty_up_o is low.
- R2: duty_level_o encodes the setting as 0=0%, 1=25%, 2=50%, 3=75%, 4=100%. With thresholds th0..th7 (index = thr_sel_i), a sample below th0 selects 0; one above th1 and below th2 selects 1; one above th3 and below th4 selects 2; one above th5 and below th6 selects 3; one above th7 selects 4.
- R3: A sample in any of the closed bands [th0,th1], [th2,th3], [th4,th5] or [th6,th7] leaves duty_level_o and duty_width_o unchanged, whatever the current level.
- R4: The level changes only in the cycle after a sample_vld_i strobe. temp_i has no effect while sample_vld_i is low.
- R5: duty_up_o is high for exactly the cycle in which duty_level_o becomes larger than its previous value, and is low at all other times.
- R6: duty_width_o equals floor(PERIOD*L/4), where L is duty_level_o. It updates in the same cycle as the level.
- R7: Within each PWM period of PERIOD cycles, pwm_o is high for the first W cycles and low for the rest, where W is the width applied to that period. At width 0 the output stays low, and at width PERIOD it stays high.
- R8: A width change takes effect only at the first cycle of the next PWM period. The period phase runs freely from reset, and pwm_o only rises at phase 0.
- R9: A write with thr_we_i replaces threshold thr_sel_i with thr_wdata_i. The write does not change the level by itself, and it governs every later sample. Out of reset the thresholds take their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld_i | input | 1 | One-cycle strobe marking a new temperature code |
| temp_i | input | TEMP_W | Raw temperature code |
| thr_we_i | input | 1 | Threshold write enable |
| thr_sel_i | input | 3 | Index of the threshold to write (0 = lowest) |
| thr_wdata_i | input | TEMP_W | New threshold value |
| duty_level_o | output | 3 | Current duty setting, 0..4 |
| duty_width_o | output | PW | High time for the current setting, in cycles |
| duty_up_o | output | 1 | Pulse when the setting increases |
| pwm_o | output | 1 | Fan PWM drive |

## Verification
The hardest case to reach is a dead band entered from a setting that is not one of its two neighbours. One example is a code in the lowest band while the level is still 100%. Another is a band reached after thresholds were moved under a level that was already set. The stimulus reaches these cases with ramps up and down across every code near the ladder, then with direct jumps from the extremes into each band, and then with all eight thresholds moved and the ramps repeated. Throughout the run, a cycle-by-cycle model of the period phase checks the output against the width latched at each period boundary.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int NUM_THR = 8;
  localparam int SEL_W   = $clog2(NUM_THR);

  typedef enum logic [2:0] {
    DUTY_0   = 3'd0,
    DUTY_25  = 3'd1,
    DUTY_50  = 3'd2,
    DUTY_75  = 3'd3,
    DUTY_100 = 3'd4
  } duty_t;

  function automatic int duty_high_cycles(input int period, input duty_t lvl);
    return (period * int'(lvl)) / 4;
  endfunction
endpackage

// File: rtl/fan_thr_regs.sv
module fan_thr_regs
  import fan_pwm_pkg::*;
#(
  parameter int TW = 10,
  parameter logic [NUM_THR*TW-1:0] INIT = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  logic [TW-1:0]               wdata,
  output logic [NUM_THR-1:0][TW-1:0]  thr_o
);
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        thr_o[g] <= INIT[g*TW +: TW];
      end else if (we && (sel == SEL_W'(g))) begin
        thr_o[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/fan_band_decide.sv
module fan_band_decide
  import fan_pwm_pkg::*;
#(
  parameter int TW     = 10,
  parameter int PERIOD = 20000,
  parameter int PW     = $clog2(PERIOD + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vld,
  input  logic [TW-1:0]               temp,
  input  logic [NUM_THR-1:0][TW-1:0]  thr,
  output duty_t                       level_o,
  output logic [PW-1:0]               width_o,
  output logic                        up_o
);
  logic [NUM_THR-1:0] at_or_above;
  logic [NUM_THR-1:0] strictly_above;

  for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
    assign at_or_above[g]    = (temp >= thr[g]);
    assign strictly_above[g] = (temp >  thr[g]);
  end

  duty_t tgt;
  logic  hold;

  always_comb begin
    tgt  = level_o;
    hold = 1'b0;
    if (!at_or_above[0])         tgt  = DUTY_0;
    else if (!strictly_above[1]) hold = 1'b1;
    else if (!at_or_above[2])    tgt  = DUTY_25;
    else if (!strictly_above[3]) hold = 1'b1;
    else if (!at_or_above[4])    tgt  = DUTY_50;
    else if (!strictly_above[5]) hold = 1'b1;
    else if (!at_or_above[6])    tgt  = DUTY_75;
    else if (!strictly_above[7]) hold = 1'b1;
    else                         tgt  = DUTY_100;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= DUTY_100;
      width_o <= PW'(PERIOD);
      up_o    <= 1'b0;
    end else begin
      up_o <= 1'b0;
      if (vld && !hold) begin
        level_o <= tgt;
        width_o <= PW'(duty_high_cycles(PERIOD, tgt));
        up_o    <= (tgt > level_o);
      end
    end
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int PERIOD = 20000,
  parameter int PW     = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] width_i,
  output logic          pwm_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase;
  logic [PW-1:0] applied;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      applied <= PW'(PERIOD);
      pwm_o   <= 1'b1;
    end else if (phase == LAST) begin
      phase   <= '0;
      applied <= width_i;
      pwm_o   <= (width_i != '0);
    end else begin
      phase   <= phase + 1'b1;
      pwm_o   <= (PW'(phase) + PW'(1)) < applied;
    end
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int TEMP_W = 10,
  parameter int PERIOD = 20000,
  parameter int TH0 = 570,
  parameter int TH1 = 601,
  parameter int TH2 = 642,
  parameter int TH3 = 683,
  parameter int TH4 = 703,
  parameter int TH5 = 724,
  parameter int TH6 = 744,
  parameter int TH7 = 754,
  localparam int PW = $clog2(PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              thr_we_i,
  input  logic [2:0]        thr_sel_i,
  input  logic [TEMP_W-1:0] thr_wdata_i,
  output logic [2:0]        duty_level_o,
  output logic [PW-1:0]     duty_width_o,
  output logic              duty_up_o,
  output logic              pwm_o
);
  localparam logic [NUM_THR*TEMP_W-1:0] THR_INIT = {
    TEMP_W'(TH7), TEMP_W'(TH6), TEMP_W'(TH5), TEMP_W'(TH4),
    TEMP_W'(TH3), TEMP_W'(TH2), TEMP_W'(TH1), TEMP_W'(TH0)
  };

  logic [NUM_THR-1:0][TEMP_W-1:0] thr;
  duty_t level;

  fan_thr_regs #(.TW(TEMP_W), .INIT(THR_INIT)) u_thr (
    .clk   (clk),
    .rst   (rst),
    .we    (thr_we_i),
    .sel   (SEL_W'(thr_sel_i)),
    .wdata (thr_wdata_i),
    .thr_o (thr)
  );

  fan_band_decide #(.TW(TEMP_W), .PERIOD(PERIOD), .PW(PW)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .vld     (sample_vld_i),
    .temp    (temp_i),
    .thr     (thr),
    .level_o (level),
    .width_o (duty_width_o),
    .up_o    (duty_up_o)
  );

  fan_pwm_gen #(.PERIOD(PERIOD), .PW(PW)) u_pwm (
    .clk     (clk),
    .rst     (rst),
    .width_i (duty_width_o),
    .pwm_o   (pwm_o)
  );

  assign duty_level_o = level;
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int PERIOD = 20000
) (
  input logic       clk,
  input logic       rst,
  input logic       sample_vld_i,
  input logic [2:0] duty_level_o,
  input logic       duty_up_o,
  input logic       pwm_o
);
  int ph;
  always_ff @(posedge clk) begin
    if (rst) ph <= 0;
    else     ph <= (ph == PERIOD - 1) ? 0 : ph + 1;
  end

  a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
    duty_level_o <= 3'd4);

  a_r4_change_needs_sample: assert property (@(posedge clk) disable iff (rst)
    (duty_level_o != $past(duty_level_o)) |-> $past(sample_vld_i));

  a_r5_up_means_rise: assert property (@(posedge clk) disable iff (rst)
    duty_up_o |-> (duty_level_o > $past(duty_level_o)));

  a_r5_rise_means_up: assert property (@(posedge clk) disable iff (rst)
    (duty_level_o > $past(duty_level_o)) |-> duty_up_o);

  a_r8_rise_at_period_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> (ph == 0));
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.PERIOD(PERIOD)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_vld_i (sample_vld_i),
  .duty_level_o (duty_level_o),
  .duty_up_o    (duty_up_o),
  .pwm_o        (pwm_o)
);

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;
  localparam int TW = 10;
  localparam int P  = 12;
  localparam int PW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_vld_i = 1'b0;
  logic [TW-1:0] temp_i = '0;
  logic thr_we_i = 1'b0;
  logic [2:0] thr_sel_i = '0;
  logic [TW-1:0] thr_wdata_i = '0;
  logic [2:0] duty_level_o;
  logic [PW-1:0] duty_width_o;
  logic duty_up_o;
  logic pwm_o;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.TEMP_W(TW), .PERIOD(P)) u0 (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int th[8] = '{570, 601, 642, 683, 703, 724, 744, 754};
  int cur = 4;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  // Model of the threshold ladder, written interval by interval
  function automatic int model(input int t, input int c);
    if (t < th[0])                   return 0;
    if (t > th[1] && t < th[2])      return 1;
    if (t > th[3] && t < th[4])      return 2;
    if (t > th[5] && t < th[6])      return 3;
    if (t > th[7])                   return 4;
    return c; // inside a dead band
  endfunction

  task automatic sample(input int t);
    int nxt;
    nxt = model(t, cur);
    sample_vld_i = 1'b1;
    temp_i = TW'(t);
    tick();
    sample_vld_i = 1'b0;
    chk((nxt == cur) ? "R3 band hold" : "R2 interval", int'(duty_level_o), nxt);
    chk("R6 width", int'(duty_width_o), (P * nxt) / 4);
    chk("R5 up pulse", int'(duty_up_o), (nxt > cur) ? 1 : 0);
    cur = nxt;
    temp_i = TW'(t ^ 10'h155);
    tick();
    chk("R5 pulse one cycle", int'(duty_up_o), 0);
    chk("R4 no strobe no change", int'(duty_level_o), cur);
  endtask

  task automatic wr_thr(input int idx, input int v);
    thr_we_i = 1'b1;
    thr_sel_i = 3'(idx);
    thr_wdata_i = TW'(v);
    tick();
    thr_we_i = 1'b0;
    th[idx] = v;
    chk("R9 write keeps level", int'(duty_level_o), cur);
  endtask

  // PWM phase model, checked on every falling edge (R7, R8)
  int n_ph = 0;
  int act_w = P;
  int w_prev = P;
  always @(negedge clk) begin
    if (rst) begin
      n_ph = 0; act_w = P; w_prev = P;
    end else if (!done) begin
      n_ph = (n_ph + 1) % P;
      if (n_ph == 0) act_w = w_prev;
      chk("R7 R8 pwm waveform", int'(pwm_o), (n_ph < act_w) ? 1 : 0);
      w_prev = int'(duty_width_o);
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset level", int'(duty_level_o), 4);
    chk("R1 reset width", int'(duty_width_o), P);
    chk("R1 reset pwm", int'(pwm_o), 1);
    chk("R1 reset up", int'(duty_up_o), 0);
    @(negedge clk);
    #1 rst = 1'b0;
    tick();
    // Dead band entered from the top level: must hold 100%
    sample(580);
    sample(620);
    // Ramps across the whole ladder
    for (int t = 560; t <= 770; t++) sample(t);
    for (int t = 770; t >= 560; t--) sample(t);
    // Jumps from extremes into each band
    for (int b = 0; b < 4; b++) begin
      sample(560);
      sample(th[2*b]);
      sample(th[2*b+1]);
      sample(770);
      sample(th[2*b+1]);
      sample(th[2*b]);
    end
    // Let a few full periods run at each level (R7)
    sample(560); repeat (2 * P) tick();
    sample(620); repeat (2 * P) tick();
    sample(770); repeat (2 * P) tick();
    // Reprogram every threshold, then sweep again (R9)
    for (int i = 0; i < 8; i++) wr_thr(i, th[i] + 3 + i);
    for (int t = 560; t <= 775; t++) sample(t);
    for (int t = 775; t >= 560; t--) sample(t);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule